// File: doc/BRIEF.md
# Memory Dependence Wakeup Scoreboard

This block keeps track of in-flight memory operations in an out-of-order core. Each operation occupies a table slot chosen by the caller (its tag). The slot holds an 8-bit sequence number, a thread ID and an operation kind. Two per-slot bits record whether the operation's source registers have arrived and whether its memory dependence is resolved. When allocated, an operation may name one producer slot. It then waits until that producer completes. Only stores and barriers act as producers.

When an operation becomes eligible, the block raises a single-cycle ready pulse on `readyValid` with the slot's tag on `readyTag`. Several operations can become eligible in the same cycle, so the block holds a pending bit per slot and emits them one per cycle.

The block also handles the following:
- It records pending load and store barriers together with their sequence numbers.
- On a per-thread flush it frees every younger operation. Age is compared modulo 2^8.
- It keeps a replay queue of deferred operations. On command, the queue is drained to the ready output in queue order.

Top module: `memDepScoreboard`

## Requirements
- R1: `allocKind` is encoded as 0 = load, 1 = store, 2 = write barrier, 3 = full barrier. Allocating a write barrier sets `storeBarPend` and loads `storeBarSeq` with its sequence number. Allocating a full barrier does the same and also sets `loadBarPend`, loading `loadBarSeq` with the same number. The flags are visible after the allocating clock edge.
- R2: Completing a full barrier clears each barrier flag only when that flag's recorded sequence number equals the barrier's own. Completing a write barrier can clear only the store flag.
- R3: An operation becomes ready only once both its register-ready bit and its dependence-resolved bit are set. An operation allocated without a producer starts with the dependence resolved. A register-ready event on an operation whose dependence is still open produces no pulse.
- R4: Completing a store or barrier wakes every live dependent. A dependent whose registers are ready becomes ready. Any other dependent only gets its dependence-resolved bit set, and a later register-ready event then makes it ready. After the wakeup the producer's dependent list is empty.
- R5: Completing a load wakes nothing, even when another operation named it as its producer.
- R6: A non-speculative event on a live slot makes it ready regardless of its two bits. The same event on a free slot is ignored.
- R7: A flush on thread T with sequence number S frees every live slot of thread T whose sequence number is younger than S. Younger means that (seq - S) mod 256 is nonzero and below 128. A freed slot never produces a ready pulse, even when its producer completes later.
- R8: A reschedule appends a tag to the replay queue. A replay command drains the whole queue, one slot per cycle in the order queued. The first slot is consumed at the replay edge itself. A slot whose operation was flushed is consumed without a pulse. `replayBusy` is high while draining continues.
- R9: A ready pulse lasts one cycle and carries one tag. It appears after the second clock edge following the event that made the slot eligible. Slots that become eligible together are emitted lowest index first, one per cycle. While the replay queue drains, ordinary pending slots wait.
- R10: After reset, `readyValid`, `replayBusy`, `loadBarPend` and `storeBarPend` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Allocate the slot named by allocTag |
| allocTag | input | 4 | Slot index to allocate |
| allocSeq | input | 8 | Sequence number of the new operation |
| allocTid | input | 1 | Thread of the new operation |
| allocKind | input | 2 | Operation kind (encoding in R1) |
| allocDepValid | input | 1 | The new operation waits on a producer |
| allocDepTag | input | 4 | Producer slot index |
| regsValid | input | 1 | Source registers ready event |
| regsTag | input | 4 | Slot of the register-ready event |
| nonSpecValid | input | 1 | Force a slot ready |
| nonSpecTag | input | 4 | Slot to force ready |
| completeValid | input | 1 | Operation completion event |
| completeTag | input | 4 | Completing slot |
| squashValid | input | 1 | Per-thread flush request |
| squashTid | input | 1 | Thread being flushed |
| squashSeq | input | 8 | Flush boundary sequence number |
| reschedValid | input | 1 | Append a slot to the replay queue |
| reschedTag | input | 4 | Slot to append |
| replayStart | input | 1 | Drain the replay queue |
| readyValid | output | 1 | Single-cycle ready pulse |
| readyTag | output | 4 | Slot of the ready pulse |
| replayBusy | output | 1 | Replay drain in progress |
| loadBarPend | output | 1 | Load barrier pending |
| loadBarSeq | output | 8 | Sequence number of the pending load barrier |
| storeBarPend | output | 1 | Store barrier pending |
| storeBarSeq | output | 8 | Sequence number of the pending store barrier |

## Verification
Some properties are checked on every cycle:
- Every ready pulse names a live slot.
- A slot's pending bit rises only when both of its bits are set, or when a non-speculative event arrived.
- The barrier flags rise only on allocation and fall only on completion.
- Draining stops only with an empty queue.

Other behaviour can only be shown by the bench's scenarios:
- Which dependents a completion wakes.
- Modulo-256 age comparison across the wrap.
- The order and count of pulses when several slots become eligible together.
- Queue-order replay with flushed slots skipped.
- Sequence-number matching when barriers clear.

// File: rtl/memDepPkg.sv
package memDepPkg;
  parameter int NUM_ENTRIES  = 16;
  parameter int NUM_THREADS  = 2;
  parameter int SEQ_W        = 8;
  parameter int REPLAY_DEPTH = 16;

  localparam int TAG_W = $clog2(NUM_ENTRIES);
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
  localparam int RQ_W  = $clog2(REPLAY_DEPTH);
  localparam int CNT_W = RQ_W + 1;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_WBAR  = 2'd2,
    KIND_FBAR  = 2'd3
  } opKindT;

  // strobes from control to the entry table
  typedef struct packed {
    logic             clrPend;
    logic [TAG_W-1:0] clrTag;
  } ctrlStrobeT;

  // a is younger than b under modulo comparison
  function automatic logic seqYounger(input logic [SEQ_W-1:0] a,
                                      input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/memDepTable.sv
module memDepTable import memDepPkg::*; (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   allocValid,
  input  logic [TAG_W-1:0]       allocTag,
  input  logic [SEQ_W-1:0]       allocSeq,
  input  logic [TID_W-1:0]       allocTid,
  input  logic [1:0]             allocKind,
  input  logic                   allocDepValid,
  input  logic [TAG_W-1:0]       allocDepTag,
  input  logic                   regsValid,
  input  logic [TAG_W-1:0]       regsTag,
  input  logic                   nonSpecValid,
  input  logic [TAG_W-1:0]       nonSpecTag,
  input  logic                   completeValid,
  input  logic [TAG_W-1:0]       completeTag,
  input  logic                   squashValid,
  input  logic [TID_W-1:0]       squashTid,
  input  logic [SEQ_W-1:0]       squashSeq,
  input  ctrlStrobeT             strobe,
  output logic [NUM_ENTRIES-1:0] entryValid,
  output logic [NUM_ENTRIES-1:0] readyPend,
  output logic [NUM_ENTRIES-1:0] regsRdy,
  output logic [NUM_ENTRIES-1:0] memOk,
  output logic [NUM_ENTRIES-1:0] freeMask,
  output logic [NUM_ENTRIES-1:0] squashMask,
  output logic                   loadBarPend,
  output logic [SEQ_W-1:0]       loadBarSeq,
  output logic                   storeBarPend,
  output logic [SEQ_W-1:0]       storeBarSeq
);
  logic [SEQ_W-1:0]       entrySeq  [NUM_ENTRIES];
  logic [TID_W-1:0]       entryTid  [NUM_ENTRIES];
  opKindT                 entryKind [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] depList   [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] validNext, regsNext, memNext, pendNext;
  logic [NUM_ENTRIES-1:0] depNext [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] wakeMask;
  logic                   compLive;
  opKindT                 compKind;
  logic [SEQ_W-1:0]       compSeq;

  assign compLive = completeValid && entryValid[completeTag];
  assign compKind = entryKind[completeTag];
  assign compSeq  = entrySeq[completeTag];
  assign wakeMask = (compLive && compKind != KIND_LOAD) ? depList[completeTag] : '0;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      squashMask[i] = squashValid && entryValid[i] && (entryTid[i] == squashTid)
                      && seqYounger(entrySeq[i], squashSeq);
      freeMask[i]   = squashMask[i] || (compLive && completeTag == TAG_W'(i));
    end
  end

  always_comb begin
    validNext = entryValid;
    regsNext  = regsRdy;
    memNext   = memOk;
    pendNext  = readyPend;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      logic nR, nM;
      nR = regsRdy[i] | (regsValid && regsTag == TAG_W'(i));
      nM = memOk[i] | wakeMask[i];
      regsNext[i] = nR;
      memNext[i]  = nM;
      depNext[i]  = depList[i] & ~freeMask;
      if (strobe.clrPend && strobe.clrTag == TAG_W'(i)) pendNext[i] = 1'b0;
      if (nR && nM && !(regsRdy[i] && memOk[i])) pendNext[i] = 1'b1;
      if (nonSpecValid && nonSpecTag == TAG_W'(i)) pendNext[i] = 1'b1;
      if (!entryValid[i] || freeMask[i]) begin
        validNext[i] = 1'b0;
        regsNext[i]  = 1'b0;
        memNext[i]   = 1'b0;
        pendNext[i]  = 1'b0;
        depNext[i]   = '0;
      end
    end
    if (allocValid) begin
      validNext[allocTag] = 1'b1;
      regsNext[allocTag]  = 1'b0;
      memNext[allocTag]   = !allocDepValid;
      pendNext[allocTag]  = 1'b0;
      depNext[allocTag]   = '0;
      for (int p = 0; p < NUM_ENTRIES; p++) depNext[p][allocTag] = 1'b0;
      if (allocDepValid) depNext[allocDepTag][allocTag] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid <= '0;
      regsRdy    <= '0;
      memOk      <= '0;
      readyPend  <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        depList[i]   <= '0;
        entrySeq[i]  <= '0;
        entryTid[i]  <= '0;
        entryKind[i] <= KIND_LOAD;
      end
    end else begin
      entryValid <= validNext;
      regsRdy    <= regsNext;
      memOk      <= memNext;
      readyPend  <= pendNext;
      for (int i = 0; i < NUM_ENTRIES; i++) depList[i] <= depNext[i];
      if (allocValid) begin
        entrySeq[allocTag]  <= allocSeq;
        entryTid[allocTag]  <= allocTid;
        entryKind[allocTag] <= opKindT'(allocKind);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadBarPend  <= 1'b0;
      storeBarPend <= 1'b0;
      loadBarSeq   <= '0;
      storeBarSeq  <= '0;
    end else begin
      if (compLive && compKind == KIND_FBAR) begin
        if (loadBarPend && loadBarSeq == compSeq) loadBarPend <= 1'b0;
        if (storeBarPend && storeBarSeq == compSeq) storeBarPend <= 1'b0;
      end else if (compLive && compKind == KIND_WBAR) begin
        if (storeBarPend && storeBarSeq == compSeq) storeBarPend <= 1'b0;
      end
      if (allocValid && (allocKind == KIND_WBAR || allocKind == KIND_FBAR)) begin
        storeBarPend <= 1'b1;
        storeBarSeq  <= allocSeq;
      end
      if (allocValid && allocKind == KIND_FBAR) begin
        loadBarPend <= 1'b1;
        loadBarSeq  <= allocSeq;
      end
    end
  end
endmodule

// File: rtl/memDepIssueCtrl.sv
module memDepIssueCtrl import memDepPkg::*; (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reschedValid,
  input  logic [TAG_W-1:0]       reschedTag,
  input  logic                   replayStart,
  input  logic [NUM_ENTRIES-1:0] readyPend,
  input  logic [NUM_ENTRIES-1:0] entryValid,
  input  logic [NUM_ENTRIES-1:0] freeMask,
  input  logic [NUM_ENTRIES-1:0] squashMask,
  output ctrlStrobeT             strobe,
  output logic                   readyValid,
  output logic [TAG_W-1:0]       readyTag,
  output logic                   replayBusy,
  output logic [CNT_W-1:0]       replayCount
);
  logic [TAG_W-1:0] slotTag  [REPLAY_DEPTH];
  logic             slotLive [REPLAY_DEPTH];
  logic [RQ_W-1:0]  headPtr, tailPtr;
  logic             draining;

  logic             popNow, pushNow, headOk;
  logic [TAG_W-1:0] headTag;
  logic             pickValid;
  logic [TAG_W-1:0] pickTag;
  logic             emitValid;
  logic [TAG_W-1:0] emitTag;
  logic [CNT_W-1:0] countNext;

  assign popNow  = (draining || replayStart) && replayCount != '0;
  assign pushNow = reschedValid && (replayCount != CNT_W'(REPLAY_DEPTH) || popNow);
  assign headTag = slotTag[headPtr];
  assign headOk  = slotLive[headPtr] && entryValid[headTag] && !freeMask[headTag];
  assign countNext = replayCount + CNT_W'(pushNow) - CNT_W'(popNow);

  // lowest index wins
  always_comb begin
    pickValid = 1'b0;
    pickTag   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (readyPend[i] && !freeMask[i]) begin
        pickValid = 1'b1;
        pickTag   = TAG_W'(i);
      end
    end
  end

  always_comb begin
    if (popNow) begin
      emitValid = headOk;
      emitTag   = headTag;
    end else begin
      emitValid = pickValid;
      emitTag   = pickTag;
    end
    strobe.clrPend = emitValid;
    strobe.clrTag  = emitTag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyValid  <= 1'b0;
      readyTag    <= '0;
      draining    <= 1'b0;
      headPtr     <= '0;
      tailPtr     <= '0;
      replayCount <= '0;
      for (int k = 0; k < REPLAY_DEPTH; k++) begin
        slotTag[k]  <= '0;
        slotLive[k] <= 1'b0;
      end
    end else begin
      readyValid <= emitValid;
      readyTag   <= emitTag;
      for (int k = 0; k < REPLAY_DEPTH; k++)
        if (squashMask[slotTag[k]]) slotLive[k] <= 1'b0;
      if (pushNow) begin
        slotTag[tailPtr]  <= reschedTag;
        slotLive[tailPtr] <= 1'b1;
        tailPtr <= tailPtr + 1'b1;
      end
      if (popNow) headPtr <= headPtr + 1'b1;
      replayCount <= countNext;
      draining    <= (draining || replayStart) && countNext != '0;
    end
  end

  assign replayBusy = draining;
endmodule

// File: rtl/memDepScoreboard.sv
module memDepScoreboard import memDepPkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic [TAG_W-1:0] allocTag,
  input  logic [SEQ_W-1:0] allocSeq,
  input  logic [TID_W-1:0] allocTid,
  input  logic [1:0]       allocKind,
  input  logic             allocDepValid,
  input  logic [TAG_W-1:0] allocDepTag,
  input  logic             regsValid,
  input  logic [TAG_W-1:0] regsTag,
  input  logic             nonSpecValid,
  input  logic [TAG_W-1:0] nonSpecTag,
  input  logic             completeValid,
  input  logic [TAG_W-1:0] completeTag,
  input  logic             squashValid,
  input  logic [TID_W-1:0] squashTid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             reschedValid,
  input  logic [TAG_W-1:0] reschedTag,
  input  logic             replayStart,
  output logic             readyValid,
  output logic [TAG_W-1:0] readyTag,
  output logic             replayBusy,
  output logic             loadBarPend,
  output logic [SEQ_W-1:0] loadBarSeq,
  output logic             storeBarPend,
  output logic [SEQ_W-1:0] storeBarSeq
);
  ctrlStrobeT             strobe;
  logic [NUM_ENTRIES-1:0] entryValid, readyPend, regsRdyVec, memOkVec;
  logic [NUM_ENTRIES-1:0] freeMask, squashMask;
  logic [CNT_W-1:0]       replayCount;

  memDepTable uTable (
    .clk, .rstN,
    .allocValid, .allocTag, .allocSeq, .allocTid, .allocKind,
    .allocDepValid, .allocDepTag,
    .regsValid, .regsTag, .nonSpecValid, .nonSpecTag,
    .completeValid, .completeTag,
    .squashValid, .squashTid, .squashSeq,
    .strobe,
    .entryValid, .readyPend,
    .regsRdy(regsRdyVec), .memOk(memOkVec),
    .freeMask, .squashMask,
    .loadBarPend, .loadBarSeq, .storeBarPend, .storeBarSeq
  );

  memDepIssueCtrl uCtrl (
    .clk, .rstN,
    .reschedValid, .reschedTag, .replayStart,
    .readyPend, .entryValid, .freeMask, .squashMask,
    .strobe,
    .readyValid, .readyTag, .replayBusy, .replayCount
  );
endmodule

// File: rtl/memDepChecker.sv
module memDepChecker import memDepPkg::*; (
  input logic                   clk,
  input logic                   rstN,
  input logic                   allocValid,
  input logic                   completeValid,
  input logic                   nonSpecValid,
  input logic                   readyValid,
  input logic [TAG_W-1:0]       readyTag,
  input logic                   replayBusy,
  input logic                   loadBarPend,
  input logic                   storeBarPend,
  input logic [NUM_ENTRIES-1:0] entryValid,
  input logic [NUM_ENTRIES-1:0] readyPend,
  input logic [NUM_ENTRIES-1:0] regsRdyVec,
  input logic [NUM_ENTRIES-1:0] memOkVec,
  input logic [CNT_W-1:0]       replayCount
);
  assert_live_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    readyValid |-> entryValid[readyTag]);

  assert_store_bar_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storeBarPend) |-> $past(allocValid));

  assert_load_bar_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loadBarPend) |-> $past(completeValid));

  assert_drain_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(replayBusy) |-> replayCount == '0);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gPend
    assert_pend_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(readyPend[i]) |-> (regsRdyVec[i] && memOkVec[i]) || $past(nonSpecValid));
  end
endmodule

bind memDepScoreboard memDepChecker uChk (
  .clk, .rstN, .allocValid, .completeValid, .nonSpecValid,
  .readyValid, .readyTag, .replayBusy, .loadBarPend, .storeBarPend,
  .entryValid, .readyPend, .regsRdyVec, .memOkVec, .replayCount
);

// File: tb/tb_memDepScoreboard.sv
`timescale 1ns/1ps
module tb_memDepScoreboard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic       allocValid = 0, allocTid = 0, allocDepValid = 0;
  logic [3:0] allocTag = 0, allocDepTag = 0;
  logic [7:0] allocSeq = 0;
  logic [1:0] allocKind = 0;
  logic       regsValid = 0, nonSpecValid = 0, completeValid = 0;
  logic [3:0] regsTag = 0, nonSpecTag = 0, completeTag = 0;
  logic       squashValid = 0, squashTid = 0;
  logic [7:0] squashSeq = 0;
  logic       reschedValid = 0, replayStart = 0;
  logic [3:0] reschedTag = 0;
  logic       readyValid, replayBusy, loadBarPend, storeBarPend;
  logic [3:0] readyTag;
  logic [7:0] loadBarSeq, storeBarSeq;

  memDepScoreboard dut (.*);

  int checks = 0, fails = 0;

  localparam logic [2:0] NOP = 0, ALLOC = 1, REGS = 2, NSPEC = 3, COMP = 4,
                         SQSH = 5, RESCH = 6, REPLAY = 7;
  localparam logic [1:0] LD = 0, ST = 1, WB = 2, FB = 3;

  typedef struct packed {
    logic [2:0] op;
    logic [3:0] tag;
    logic [7:0] seq;
    logic       tid;
    logic [1:0] kind;
    logic       depV;
    logic [3:0] depTag;
    logic       expV;
    logic [3:0] expTag;
    logic [3:0] req;
  } vecT;

  localparam int NV = 27;
  localparam vecT VECS [NV] = '{
    '{ALLOC, 4'd0, 8'd10, 1'b0, ST, 1'b0, 4'd0, 1'b0, 4'd0, 4'd3},  // R3
    '{ALLOC, 4'd1, 8'd11, 1'b0, LD, 1'b1, 4'd0, 1'b0, 4'd0, 4'd3},
    '{REGS,  4'd1, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd3},  // R3 waits
    '{REGS,  4'd0, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b1, 4'd0, 4'd3},
    '{COMP,  4'd0, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b1, 4'd1, 4'd4},  // R4 immediate
    '{ALLOC, 4'd3, 8'd13, 1'b0, ST, 1'b0, 4'd0, 1'b0, 4'd0, 4'd4},
    '{ALLOC, 4'd2, 8'd14, 1'b0, LD, 1'b1, 4'd3, 1'b0, 4'd0, 4'd4},
    '{COMP,  4'd3, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd4},  // R4 only resolve
    '{REGS,  4'd2, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b1, 4'd2, 4'd4},
    '{ALLOC, 4'd4, 8'd15, 1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd5},
    '{ALLOC, 4'd5, 8'd16, 1'b0, LD, 1'b1, 4'd4, 1'b0, 4'd0, 4'd5},
    '{REGS,  4'd5, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd5},
    '{COMP,  4'd4, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd5},  // R5
    '{NSPEC, 4'd5, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b1, 4'd5, 4'd6},  // R6
    '{ALLOC, 4'd6, 8'd20, 1'b1, ST, 1'b0, 4'd0, 1'b0, 4'd0, 4'd7},
    '{ALLOC, 4'd7, 8'd21, 1'b1, LD, 1'b1, 4'd6, 1'b0, 4'd0, 4'd7},
    '{ALLOC, 4'd8, 8'd22, 1'b0, LD, 1'b1, 4'd6, 1'b0, 4'd0, 4'd7},
    '{REGS,  4'd7, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd7},
    '{REGS,  4'd8, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd7},
    '{SQSH,  4'd0, 8'd20, 1'b1, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd7},  // R7
    '{COMP,  4'd6, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b1, 4'd8, 4'd7},
    '{ALLOC, 4'd9, 8'd250,1'b0, ST, 1'b0, 4'd0, 1'b0, 4'd0, 4'd7},
    '{ALLOC, 4'd10,8'd3,  1'b0, LD, 1'b1, 4'd9, 1'b0, 4'd0, 4'd7},
    '{REGS,  4'd10,8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd7},
    '{SQSH,  4'd0, 8'd252,1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd7},  // R7 wrap
    '{COMP,  4'd9, 8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd7},
    '{NSPEC, 4'd10,8'd0,  1'b0, LD, 1'b0, 4'd0, 1'b0, 4'd0, 4'd6}   // R6 free slot
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doOp(input vecT v);
    case (v.op)
      ALLOC: begin
        allocValid = 1; allocTag = v.tag; allocSeq = v.seq; allocTid = v.tid;
        allocKind = v.kind; allocDepValid = v.depV; allocDepTag = v.depTag;
      end
      REGS:   begin regsValid = 1; regsTag = v.tag; end
      NSPEC:  begin nonSpecValid = 1; nonSpecTag = v.tag; end
      COMP:   begin completeValid = 1; completeTag = v.tag; end
      SQSH:   begin squashValid = 1; squashTid = v.tid; squashSeq = v.seq; end
      RESCH:  begin reschedValid = 1; reschedTag = v.tag; end
      REPLAY: replayStart = 1;
      default: ;
    endcase
    tick();
    allocValid = 0; regsValid = 0; nonSpecValid = 0; completeValid = 0;
    squashValid = 0; reschedValid = 0; replayStart = 0;
  endtask

  function automatic vecT mk(input logic [2:0] op, input logic [3:0] tag,
                             input logic [7:0] seq, input logic tid,
                             input logic [1:0] kind, input logic depV,
                             input logic [3:0] depTag);
    return '{op, tag, seq, tid, kind, depV, depTag, 1'b0, 4'd0, 4'd0};
  endfunction

  task automatic expectPulse(input bit v, input logic [3:0] t, input string req);
    check(readyValid == v, req, readyValid, v);
    if (v) check(readyTag == t, req, readyTag, t);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    // R10 reset state
    check(readyValid == 0, "R10", readyValid, 0);
    check(replayBusy == 0, "R10", replayBusy, 0);
    check(loadBarPend == 0 && storeBarPend == 0, "R10", {loadBarPend, storeBarPend}, 0);

    for (int n = 0; n < NV; n++) begin
      doOp(VECS[n]);
      tick();
      expectPulse(VECS[n].expV, VECS[n].expTag, $sformatf("R%0d vec%0d", VECS[n].req, n));
    end

    // R1 / R2 barriers
    doOp(mk(ALLOC, 4'd11, 8'd40, 1'b0, FB, 1'b0, 4'd0));
    check(loadBarPend && storeBarPend, "R1", {loadBarPend, storeBarPend}, 3);
    check(loadBarSeq == 40 && storeBarSeq == 40, "R1", storeBarSeq, 40);
    doOp(mk(ALLOC, 4'd12, 8'd41, 1'b0, WB, 1'b0, 4'd0));
    check(storeBarSeq == 41 && loadBarSeq == 40, "R1", storeBarSeq, 41);
    doOp(mk(COMP, 4'd11, 8'd0, 1'b0, LD, 1'b0, 4'd0));
    check(!loadBarPend, "R2", loadBarPend, 0);
    check(storeBarPend, "R2", storeBarPend, 1);
    doOp(mk(COMP, 4'd12, 8'd0, 1'b0, LD, 1'b0, 4'd0));
    check(!storeBarPend, "R2", storeBarPend, 0);

    // R9 multiple wakeups, lowest index first
    doOp(mk(ALLOC, 4'd0, 8'd50, 1'b0, ST, 1'b0, 4'd0));
    doOp(mk(ALLOC, 4'd1, 8'd51, 1'b0, LD, 1'b1, 4'd0));
    doOp(mk(ALLOC, 4'd2, 8'd52, 1'b0, LD, 1'b1, 4'd0));
    doOp(mk(REGS, 4'd2, 8'd0, 1'b0, LD, 1'b0, 4'd0));
    doOp(mk(REGS, 4'd1, 8'd0, 1'b0, LD, 1'b0, 4'd0));
    doOp(mk(COMP, 4'd0, 8'd0, 1'b0, LD, 1'b0, 4'd0));
    expectPulse(0, 0, "R9");
    tick(); expectPulse(1, 4'd1, "R9");
    tick(); expectPulse(1, 4'd2, "R9");
    tick(); expectPulse(0, 0, "R9");

    // R8 replay drain in queue order, flushed slot skipped
    doOp(mk(ALLOC, 4'd3, 8'd60, 1'b1, LD, 1'b0, 4'd0));
    doOp(mk(ALLOC, 4'd4, 8'd61, 1'b1, LD, 1'b0, 4'd0));
    doOp(mk(ALLOC, 4'd5, 8'd62, 1'b1, LD, 1'b0, 4'd0));
    doOp(mk(RESCH, 4'd5, 8'd0, 1'b0, LD, 1'b0, 4'd0));
    doOp(mk(RESCH, 4'd3, 8'd0, 1'b0, LD, 1'b0, 4'd0));
    doOp(mk(RESCH, 4'd4, 8'd0, 1'b0, LD, 1'b0, 4'd0));
    doOp(mk(SQSH, 4'd0, 8'd61, 1'b1, LD, 1'b0, 4'd0));
    doOp(mk(REPLAY, 4'd0, 8'd0, 1'b0, LD, 1'b0, 4'd0));
    expectPulse(0, 0, "R8");
    check(replayBusy, "R8", replayBusy, 1);
    tick(); expectPulse(1, 4'd3, "R8");
    tick(); expectPulse(1, 4'd4, "R8");
    check(!replayBusy, "R8", replayBusy, 0);
    tick(); expectPulse(0, 0, "R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule